// File: doc/BRIEF.md
# Palette Color Lookup with Format Re-encoding

This block is the color lookup table behind the palettized display modes. A register bus writes 128 words of 32 bits into a window at byte offsets 0x200 through 0x3FC. Each word carries two 16-bit color entries. Each entry has three 5-bit channels and one unused intensity bit. The block keeps every word as written, so software reads back the same value it stored.

On each write, both halves are expanded to 8 bits per channel and re-encoded into the pixel format that `fmt_sel` chooses. The results go into a 256-entry lookup. The pixel pipeline presents an 8-bit index and gets the encoded color one clock later.

When `fmt_sel` changes, a background sweep rebuilds every lookup entry from the stored words, one entry per clock. `busy` stays high while the sweep runs. A bus write that lands during the sweep takes the lookup write port for that cycle, and the sweep waits one cycle.

Top module: `palette_lut`

## Requirements
- R1: Byte addresses 0x200 to 0x3FF select word (address − 0x200) >> 2. `bus_rdata` returns that word exactly as last written. Any other address reads 0.
- R2: In each 16-bit half, red is bits 4:0, green is bits 9:5 and blue is bits 14:10. Each channel is widened to 8 bits by shifting left by 3. Bit 15 has no effect on any lookup result.
- R3: The low half of word n feeds lookup entry 2n and the high half feeds entry 2n+1.
- R4: With `fmt_sel` = 0 (8-bit), the color is R[7:5] at bits 7:5, G[7:5] at bits 4:2 and B[7:6] at bits 1:0. All higher bits are 0.
- R5: With `fmt_sel` = 1 (15-bit), the color is R[7:3] at bits 14:10, G[7:3] at bits 9:5 and B[7:3] at bits 4:0. All higher bits are 0.
- R6: With `fmt_sel` = 2 (16-bit), the color is R[7:3] at bits 15:11, G[7:2] at bits 10:5 and B[7:3] at bits 4:0. All higher bits are 0.
- R7: With `fmt_sel` = 3 (24/32-bit), the color is R at bits 23:16, G at bits 15:8 and B at bits 7:0.
- R8: `lut_color` shows the entry for the `lut_idx` sampled at the previous rising clock edge. It holds its old value until that edge.
- R9: A change of `fmt_sel` raises `busy` at the next edge. The lookup is then rebuilt from the stored words, one entry per cycle. With no bus writes in between, `busy` stays high for exactly 256 cycles. After that every entry is in the new format.
- R10: A bus write during the sweep stalls the sweep for that one cycle, which makes `busy` one cycle longer. The written entries end up in the new format.
- R11: A write with `bus_wr` high to an address outside 0x200 to 0x3FF changes neither the stored words nor the lookup.
- R12: After reset, `busy` is 0, every stored word reads 0 and every lookup entry is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 12 | Byte address of the register bus |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data: two packed 16-bit entries |
| bus_rdata | output | 32 | Raw word readback, combinational |
| fmt_sel | input | 2 | Output pixel format: 0 8-bit, 1 15-bit, 2 16-bit, 3 24/32-bit |
| lut_idx | input | 8 | Lookup index from the pixel side |
| lut_color | output | 24 | Encoded color, one cycle after the index |
| busy | output | 1 | High while the lookup is rebuilt after a format change |

## Verification
The assertions check on every cycle the properties that local signals can show. A stored word matches the data written. The two lookup write ports never act in the same cycle. A sweep starts at entry 0, holds its counter when stalled and ends only after entry 255. Outside a sweep, the colors read back never set bits that the current format leaves unused.

The exact bit layout of each format, the mapping from halves to entries, the ignored intensity bit and the one-cycle lookup latency are shown only by the bench scenarios. The same is true of the sweep length with and without an injected write, and of out-of-range writes leaving everything unchanged. The bench compares these against its own model of the packing.

// File: rtl/pal_pkg.sv
package pal_pkg;

  localparam int PIX_W  = 24;
  localparam int HALF_W = 16;

  typedef enum logic [1:0] {
    FMT_RGB332 = 2'd0,
    FMT_RGB555 = 2'd1,
    FMT_RGB565 = 2'd2,
    FMT_RGB888 = 2'd3
  } pix_fmt_e;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb8_t;

  // Widen the three 5-bit channels of one packed entry; bit 15 is dropped.
  function automatic rgb8_t widen_entry(input logic [HALF_W-1:0] h);
    rgb8_t c;
    c.r = {h[4:0],   3'b000};
    c.g = {h[9:5],   3'b000};
    c.b = {h[14:10], 3'b000};
    return c;
  endfunction

  // Re-encode an 8-bit-per-channel color into the selected pixel format.
  function automatic logic [PIX_W-1:0] encode_pix(input pix_fmt_e f, input rgb8_t c);
    logic [PIX_W-1:0] p;
    p = '0;
    case (f)
      FMT_RGB332: p[7:0]  = {c.r[7:5], c.g[7:5], c.b[7:6]};
      FMT_RGB555: p[14:0] = {c.r[7:3], c.g[7:3], c.b[7:3]};
      FMT_RGB565: p[15:0] = {c.r[7:3], c.g[7:2], c.b[7:3]};
      default:    p       = {c.r, c.g, c.b};
    endcase
    return p;
  endfunction

  // Bits that a format never uses.
  function automatic logic [PIX_W-1:0] unused_mask(input pix_fmt_e f);
    case (f)
      FMT_RGB332: return 24'hFFFF00;
      FMT_RGB555: return 24'hFF8000;
      FMT_RGB565: return 24'hFF0000;
      default:    return 24'h000000;
    endcase
  endfunction

endpackage

// File: rtl/pal_raw_store.sv
module pal_raw_store #(
  parameter int WORDS  = 128,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_idx_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [AW-1:0]     rd_idx_b,
  output logic [DATA_W-1:0] rd_data_b
);

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign rd_data_a = mem[rd_idx_a];
  assign rd_data_b = mem[rd_idx_b];

  // R1: a stored word equals the data written one cycle earlier
  p_store_keeps_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(wr_idx)] == $past(wr_data));

endmodule

// File: rtl/pal_sweep.sv
module pal_sweep #(
  parameter int ENTRIES = 256,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pal_pkg::pix_fmt_e fmt_in,
  input  logic             stall,
  output pal_pkg::pix_fmt_e fmt_q,
  output logic             busy,
  output logic [IW-1:0]    cnt,
  output logic             sweep_we
);

  localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

  logic fmt_change;
  assign fmt_change = (fmt_in != fmt_q);
  assign sweep_we   = busy && !stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q <= pal_pkg::FMT_RGB332;
      busy  <= 1'b0;
      cnt   <= '0;
    end else if (fmt_change) begin
      fmt_q <= fmt_in;
      busy  <= 1'b1;
      cnt   <= '0;
    end else if (sweep_we) begin
      if (cnt == LAST) busy <= 1'b0;
      cnt <= cnt + 1'b1;
    end
  end

  // R9: a sweep always starts from entry 0
  p_sweep_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> cnt == '0);

  // R9: a sweep ends only after the last entry was written
  p_sweep_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(cnt) == LAST && $past(sweep_we));

  // R10: a stalled sweep holds its position
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && stall && !fmt_change |=> cnt == $past(cnt));

endmodule

// File: rtl/pal_lut.sv
module pal_lut #(
  parameter int WORDS = 128,
  parameter int PIX_W = 24,
  localparam int AW   = $clog2(WORDS),
  localparam int IW   = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_pair,
  input  logic [AW-1:0]    pair_idx,
  input  logic [PIX_W-1:0] pair_lo,
  input  logic [PIX_W-1:0] pair_hi,
  input  logic             we_one,
  input  logic [IW-1:0]    one_idx,
  input  logic [PIX_W-1:0] one_val,
  input  logic [IW-1:0]    rd_idx,
  output logic [PIX_W-1:0] rd_color
);

  logic [PIX_W-1:0] lo_mem [WORDS];
  logic [PIX_W-1:0] hi_mem [WORDS];

  logic [AW-1:0] one_pair, rd_pair;
  assign one_pair = AW'(one_idx >> 1);
  assign rd_pair  = AW'(rd_idx >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) begin
        lo_mem[i] <= '0;
        hi_mem[i] <= '0;
      end
    end else if (we_pair) begin
      lo_mem[pair_idx] <= pair_lo;
      hi_mem[pair_idx] <= pair_hi;
    end else if (we_one) begin
      if (one_idx[0]) hi_mem[one_pair] <= one_val;
      else            lo_mem[one_pair] <= one_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_color <= '0;
    else        rd_color <= rd_idx[0] ? hi_mem[rd_pair] : lo_mem[rd_pair];
  end

  // R10: bus and sweep never write the lookup in the same cycle
  p_one_writer_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_pair && we_one));

endmodule

// File: rtl/palette_lut.sv
module palette_lut #(
  parameter int          ADDR_W    = 12,
  parameter int          DATA_W    = 32,
  parameter int          WORDS     = 128,
  parameter logic [11:0] BASE_ADDR = 12'h200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [1:0]        fmt_sel,
  input  logic [7:0]        lut_idx,
  output logic [23:0]       lut_color,
  output logic              busy
);
  import pal_pkg::*;

  localparam int AW      = $clog2(WORDS);
  localparam int ENTRIES = 2 * WORDS;
  localparam int IW      = $clog2(ENTRIES);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(WORDS * 4);

  // Address decode
  logic [ADDR_W-1:0] off;
  logic              hit;
  logic [AW-1:0]     word_idx;
  logic              bus_we;
  assign off      = bus_addr - ADDR_W'(BASE_ADDR);
  assign hit      = (bus_addr >= ADDR_W'(BASE_ADDR)) && (off < SPAN);
  assign word_idx = AW'(off >> 2);
  assign bus_we   = bus_wr && hit;

  // Sweep control
  pix_fmt_e      fmt_q;
  logic [IW-1:0] sweep_cnt;
  logic          sweep_we;
  logic [DATA_W-1:0] raw_a, raw_b;

  pal_sweep #(.ENTRIES(ENTRIES)) u_sweep (
    .clk(clk), .rst_n(rst_n), .fmt_in(pix_fmt_e'(fmt_sel)), .stall(bus_we),
    .fmt_q(fmt_q), .busy(busy), .cnt(sweep_cnt), .sweep_we(sweep_we)
  );

  pal_raw_store #(.WORDS(WORDS), .DATA_W(DATA_W)) u_raw (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .wr_idx(word_idx),
    .wr_data(bus_wdata), .rd_idx_a(word_idx), .rd_data_a(raw_a),
    .rd_idx_b(AW'(sweep_cnt >> 1)), .rd_data_b(raw_b)
  );

  assign bus_rdata = hit ? raw_a : '0;

  // Conversion paths
  logic [PIX_W-1:0] wr_lo, wr_hi, sw_val;
  logic [HALF_W-1:0] sw_half;
  assign wr_lo   = encode_pix(fmt_q, widen_entry(bus_wdata[HALF_W-1:0]));
  assign wr_hi   = encode_pix(fmt_q, widen_entry(bus_wdata[2*HALF_W-1:HALF_W]));
  assign sw_half = sweep_cnt[0] ? raw_b[2*HALF_W-1:HALF_W] : raw_b[HALF_W-1:0];
  assign sw_val  = encode_pix(fmt_q, widen_entry(sw_half));

  pal_lut #(.WORDS(WORDS), .PIX_W(PIX_W)) u_lut (
    .clk(clk), .rst_n(rst_n),
    .we_pair(bus_we), .pair_idx(word_idx), .pair_lo(wr_lo), .pair_hi(wr_hi),
    .we_one(sweep_we), .one_idx(sweep_cnt), .one_val(sw_val),
    .rd_idx(lut_idx), .rd_color(lut_color)
  );

  // R4 R5 R6 R7: outside a sweep, no color uses bits its format leaves empty
  p_fmt_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && $past(!busy) && $stable(fmt_q)
      |-> (lut_color & unused_mask(fmt_q)) == '0);

endmodule

// File: tb/palette_lut_tb_top.sv
`timescale 1ns/1ps
module palette_lut_tb_top;

  localparam int CLK_PER = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  fmt_sel = 2'd0;
  logic [7:0]  lut_idx = '0;
  logic [23:0] lut_color;
  logic        busy;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] shadow [128];

  always #(CLK_PER/2) clk = ~clk;

  palette_lut dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fmt_sel(fmt_sel),
    .lut_idx(lut_idx), .lut_color(lut_color), .busy(busy)
  );

  localparam logic [1:0]  V_FMT  [8] = '{2'd0, 2'd0, 2'd1, 2'd1, 2'd2, 2'd2, 2'd3, 2'd3};
  localparam logic [11:0] V_ADDR [8] = '{12'h200, 12'h204, 12'h3FC, 12'h208,
                                         12'h20C, 12'h2A0, 12'h210, 12'h300};
  localparam logic [31:0] V_DATA [8] = '{32'h0000_001F, 32'h83E0_7C00, 32'h1234_ABCD,
                                         32'hFFFF_8000, 32'h03E0_5555, 32'h7FFF_2AAA,
                                         32'h4210_0421, 32'hDEAD_BEEF};

  function automatic logic [23:0] model(input logic [1:0] f, input logic [15:0] h);
    logic [4:0] r, g, b;
    r = h[4:0]; g = h[9:5]; b = h[14:10];
    case (f)
      2'd0:    return {16'h0, r[4:2], g[4:2], b[4:3]};
      2'd1:    return {9'h0, r, g, b};
      2'd2:    return {8'h0, r, g, 1'b0, b};
      default: return {r, 3'b0, g, 3'b0, b, 3'b0};
    endcase
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a >= 12'h200 && a < 12'h400) shadow[(a - 12'h200) >> 2] = d;
  endtask

  task automatic read_raw(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic lookup(input logic [7:0] idx, output logic [23:0] c);
    @(negedge clk);
    lut_idx = idx;
    @(negedge clk);
    c = lut_color;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  initial begin
    #(CLK_PER * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [23:0] c;
    int nb;
    for (int i = 0; i < 128; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12: reset state
    @(negedge clk);
    check(busy == 1'b0, "R12 busy", {31'b0, busy}, 32'h0);
    read_raw(12'h3F8, rd);
    check(rd == 32'h0, "R12 raw", rd, 32'h0);
    lookup(8'd255, c);
    check(c == 24'h0, "R12 lut", {8'h0, c}, 32'h0);

    // Vector walk: R1 R2 R3 and the per-format layouts
    for (int v = 0; v < 8; v++) begin
      logic [31:0] d;
      logic [7:0]  e;
      string       tag;
      d = V_DATA[v];
      e = 8'(((V_ADDR[v] - 12'h200) >> 2) * 2);
      case (V_FMT[v])
        2'd0: tag = "R2 R3 R4";
        2'd1: tag = "R2 R3 R5";
        2'd2: tag = "R2 R3 R6";
        default: tag = "R2 R3 R7";
      endcase
      @(negedge clk);
      fmt_sel = V_FMT[v];
      wait_idle();
      bus_write(V_ADDR[v], d);
      read_raw(V_ADDR[v], rd);
      check(rd == d, "R1 readback", rd, d);
      lookup(e, c);
      check(c == model(V_FMT[v], d[15:0]), tag, {8'h0, c}, {8'h0, model(V_FMT[v], d[15:0])});
      lookup(e + 8'd1, c);
      check(c == model(V_FMT[v], d[31:16]), tag, {8'h0, c}, {8'h0, model(V_FMT[v], d[31:16])});
    end

    // R1: out-of-window read returns 0
    read_raw(12'h1FC, rd);
    check(rd == 32'h0, "R1 outside", rd, 32'h0);

    // R8: latency of exactly one cycle (entries 0 and 1 differ)
    @(negedge clk);
    lut_idx = 8'd0;
    @(negedge clk);
    lut_idx = 8'd1;
    #1;
    check(lut_color == model(fmt_sel, shadow[0][15:0]), "R8 hold", {8'h0, lut_color},
          {8'h0, model(fmt_sel, shadow[0][15:0])});
    @(negedge clk);
    check(lut_color == model(fmt_sel, shadow[0][31:16]), "R8 update", {8'h0, lut_color},
          {8'h0, model(fmt_sel, shadow[0][31:16])});

    // R11: writes outside the window are ignored
    bus_write(12'h100, 32'hFFFF_FFFF);
    bus_write(12'h600, 32'hFFFF_FFFF);
    read_raw(12'h300, rd);
    check(rd == shadow[64], "R11 raw 64", rd, shadow[64]);
    read_raw(12'h200, rd);
    check(rd == shadow[0], "R11 raw 0", rd, shadow[0]);
    lookup(8'd128, c);
    check(c == model(fmt_sel, shadow[64][15:0]), "R11 lut", {8'h0, c},
          {8'h0, model(fmt_sel, shadow[64][15:0])});

    // R9: format change sweep of 256 cycles, entries reconverted
    @(negedge clk);
    fmt_sel = 2'd1;
    nb = 0;
    forever begin
      @(negedge clk);
      if (!busy) break;
      nb++;
    end
    check(nb == 256, "R9 sweep length", nb, 256);
    for (int k = 0; k < 4; k++) begin
      logic [7:0] ix;
      logic [15:0] h;
      ix = (k == 0) ? 8'd0 : (k == 1) ? 8'd129 : (k == 2) ? 8'd255 : 8'd9;
      h = ix[0] ? shadow[ix >> 1][31:16] : shadow[ix >> 1][15:0];
      lookup(ix, c);
      check(c == model(2'd1, h), "R9 reconvert", {8'h0, c}, {8'h0, model(2'd1, h)});
    end

    // R10: bus write in the middle of a sweep
    @(negedge clk);
    fmt_sel = 2'd2;
    nb = 0;
    forever begin
      @(negedge clk);
      bus_wr = 1'b0;
      if (!busy) break;
      nb++;
      if (nb == 10) begin
        bus_addr = 12'h3F0; bus_wdata = 32'h5A5A_A5A5; bus_wr = 1'b1;
        shadow[124] = 32'h5A5A_A5A5;
      end
    end
    check(nb == 257, "R10 stall length", nb, 257);
    lookup(8'd248, c);
    check(c == model(2'd2, 16'hA5A5), "R10 lo", {8'h0, c}, {8'h0, model(2'd2, 16'hA5A5)});
    lookup(8'd249, c);
    check(c == model(2'd2, 16'h5A5A), "R10 hi", {8'h0, c}, {8'h0, model(2'd2, 16'h5A5A)});
    lookup(8'd2, c);
    check(c == model(2'd2, shadow[1][15:0]), "R10 other", {8'h0, c},
          {8'h0, model(2'd2, shadow[1][15:0])});

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule